// File: doc/BRIEF.md
# Host Port Pin Function Multiplexer

This block sits between five shared pads of a host port and the host protocol engine. Each pad can take a host-bus role or act as a general-purpose I/O line. The role depends on a set of enable bits in a local control register and on two mode inputs from elsewhere in the chip. The modes are single versus double request signalling, and a multiplexed versus a non-multiplexed address bus. For every pad the block decides whether the pad is a host input, a host output or GPIO. It then drives the pad's output value and its tri-state enable, and steers sampled pad levels to the engine.

A small local register bus writes and reads three registers: the control register, a GPIO direction register and a GPIO data register. A read of the data register returns the live level of GPIO inputs. Register writes take effect at the next clock edge. The pad roles follow combinationally from the stored registers and the mode inputs. The block has no data stream, so every port is a plain level signal with no valid/ready handshake.

Pad indices, used in every 5-bit vector: bit 0 request/transmit-request pad, bit 1 acknowledge/receive-request pad, bit 2 chip-select/A10 pad, bit 3 A9 pad, bit 4 A8 pad.

Top module: `hpm_top`

## Requirements
- R1: After reset, the control, direction and data registers are 0. Every pad is GPIO (`pin_is_host` = 0) with `pin_oe` = 0, and a data read returns 0.
- R2: Register addresses are 0 = control, 1 = direction and 2 = data. A write with `reg_we` high is visible on `reg_rdata` after the next rising edge. Address 3 reads 0 and ignores writes. Control bits are: bit 0 GPIO global enable, bit 1 A8 enable, bit 2 A9 enable, bit 3 chip-select enable, bit 4 request enable and bit 5 acknowledge enable.
- R3: In single request mode (`dbl_req_mode` = 0) with request enable set, pad 0 is a host output that drives `eng_txreq`.
- R4: In single request mode, pad 1 is the host acknowledge input only when both acknowledge enable and request enable are set. In that case `eng_ack` follows the pad level. Otherwise pad 1 is GPIO.
- R5: In double request mode with request enable set, pads 0 and 1 are host outputs driving `eng_txreq` and `eng_rxreq`. Acknowledge enable has no effect on any pad in this mode.
- R6: With request enable clear, pads 0 and 1 are GPIO in both request modes.
- R7: With chip-select enable set, pad 2 is a host input. Its level goes to `eng_cs` when `mux_bus_mode` = 0 and to `eng_a10` when `mux_bus_mode` = 1. With the bit clear, pad 2 is GPIO.
- R8: The A9 and A8 enables make pads 3 and 4 host address inputs (`eng_a9`, `eng_a8`) only when `mux_bus_mode` = 1. On a non-multiplexed bus they are ignored and the pads stay GPIO.
- R9: A GPIO pad with direction bit 1 and GPIO global enable set has `pin_oe` = 1 and drives its data-register bit.
- R10: A GPIO pad with direction bit 0 reads its pad level in the data register when the GPIO global enable is set, and reads 0 when it is clear. With the GPIO global enable clear, no GPIO pad is driven, and GPIO output pads read back their stored data bit.
- R11: Host-role pads do not depend on the GPIO global enable. A host output always has `pin_oe` = 1, and a host input has `pin_oe` = 0. Each engine-side input reads 0 whenever its pad is not in that role.
- R12: A pad in a host role reads 0 in the data register, whatever its stored data bit is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| dbl_req_mode | input | 1 | 1 = double request mode |
| mux_bus_mode | input | 1 | 1 = multiplexed address bus |
| eng_txreq | input | 1 | Request / transmit-request level from engine |
| eng_rxreq | input | 1 | Receive-request level from engine |
| eng_ack | output | 1 | Acknowledge level to engine |
| eng_cs | output | 1 | Chip-select level to engine |
| eng_a10 | output | 1 | Address line 10 to engine |
| eng_a9 | output | 1 | Address line 9 to engine |
| eng_a8 | output | 1 | Address line 8 to engine |
| pin_in | input | 5 | Sampled pad levels |
| pin_out | output | 5 | Pad output values |
| pin_oe | output | 5 | Pad output enables |
| pin_is_host | output | 5 | 1 where the pad has a host role |

## Verification
The assertions assume that the mode inputs and the register-bus inputs are known (not X) outside reset. They also assume that `reg_addr` is stable in any cycle in which `reg_we` is high. The bench changes every input only on the falling clock edge and holds each write for exactly one rising edge. Mode inputs change only between directed scenarios or at half-cycle points, so each combinational role change settles before the next sampling point.

// File: rtl/hpm_pkg.sv
package hpm_pkg;
  localparam int NPINS  = 5;
  localparam int CTRL_W = 6;

  localparam int PIN_REQ = 0;
  localparam int PIN_ACK = 1;
  localparam int PIN_CS  = 2;
  localparam int PIN_A9  = 3;
  localparam int PIN_A8  = 4;

  localparam int C_GPIO = 0;
  localparam int C_A8   = 1;
  localparam int C_A9   = 2;
  localparam int C_CS   = 3;
  localparam int C_REQ  = 4;
  localparam int C_ACK  = 5;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DIR  = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  typedef enum logic [1:0] {
    ROLE_GPIO     = 2'd0,
    ROLE_HOST_IN  = 2'd1,
    ROLE_HOST_OUT = 2'd2
  } role_e;
endpackage

// File: rtl/hpm_regs.sv
module hpm_regs
  import hpm_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  dat_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      dir_q  <= '0;
      dat_q  <= '0;
    end else if (we) begin
      case (addr)
        A_CTRL:  ctrl_q <= wdata[CTRL_W-1:0];
        A_DIR:   dir_q  <= wdata[NPINS-1:0];
        A_DATA:  dat_q  <= wdata[NPINS-1:0];
        default: ;
      endcase
    end
  end

  AST_CTRL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_CTRL) |=> ctrl_q == $past(wdata[CTRL_W-1:0])); // R2
  AST_DIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == A_DIR) |=> $stable(dir_q)); // R2
endmodule

// File: rtl/hpm_role_decode.sv
module hpm_role_decode
  import hpm_pkg::*;
(
  input  logic [CTRL_W-1:0]   ctrl,
  input  logic                dbl_req_mode,
  input  logic                mux_bus_mode,
  output role_e [NPINS-1:0]   role
);
  always_comb begin
    role = {NPINS{ROLE_GPIO}};
    if (ctrl[C_REQ]) begin
      role[PIN_REQ] = ROLE_HOST_OUT;
      if (dbl_req_mode)
        role[PIN_ACK] = ROLE_HOST_OUT;
      else if (ctrl[C_ACK])
        role[PIN_ACK] = ROLE_HOST_IN;
    end
    if (ctrl[C_CS])
      role[PIN_CS] = ROLE_HOST_IN;
    if (mux_bus_mode && ctrl[C_A9])
      role[PIN_A9] = ROLE_HOST_IN;
    if (mux_bus_mode && ctrl[C_A8])
      role[PIN_A8] = ROLE_HOST_IN;
  end
endmodule

// File: rtl/hpm_pin_cell.sv
module hpm_pin_cell
  import hpm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  role_e role,
  input  logic  gpio_en,
  input  logic  dir,
  input  logic  dat,
  input  logic  host_drv,
  input  logic  pad_in,
  output logic  pad_out,
  output logic  pad_oe,
  output logic  rd_bit,
  output logic  host_rx
);
  logic is_gpio;

  always_comb begin
    is_gpio = (role == ROLE_GPIO);
    pad_oe  = (role == ROLE_HOST_OUT) || (is_gpio && gpio_en && dir);
    if (role == ROLE_HOST_OUT) pad_out = host_drv;
    else if (is_gpio)          pad_out = dat;
    else                       pad_out = 1'b0;
    if (!is_gpio)  rd_bit = 1'b0;
    else if (dir)  rd_bit = dat;
    else           rd_bit = gpio_en && pad_in;
    host_rx = (role == ROLE_HOST_IN) ? pad_in : 1'b0;
  end

  AST_GPIO_OFF_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (role == ROLE_GPIO && !gpio_en) |-> !pad_oe); // R10
  AST_GPIO_OFF_IN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (role == ROLE_GPIO && !gpio_en && !dir) |-> !rd_bit); // R10
  AST_HOST_OUT_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (role == ROLE_HOST_OUT) |-> (pad_oe && pad_out == host_drv && !rd_bit)); // R11
  AST_HOST_IN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (role == ROLE_HOST_IN) |-> (!pad_oe && host_rx == pad_in && !rd_bit)); // R11
endmodule

// File: rtl/hpm_top.sv
module hpm_top
  import hpm_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             dbl_req_mode,
  input  logic             mux_bus_mode,
  input  logic             eng_txreq,
  input  logic             eng_rxreq,
  output logic             eng_ack,
  output logic             eng_cs,
  output logic             eng_a10,
  output logic             eng_a9,
  output logic             eng_a8,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] pin_is_host
);
  localparam int CTRL_PAD = REG_W - CTRL_W;
  localparam int PIN_PAD  = REG_W - NPINS;

  logic [CTRL_W-1:0] ctrl_q;
  logic [NPINS-1:0]  dir_q, dat_q, rd_vec, rx_vec, drv_vec;
  role_e [NPINS-1:0] role;

  hpm_regs #(.REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .ctrl_q(ctrl_q), .dir_q(dir_q), .dat_q(dat_q)
  );

  hpm_role_decode u_dec (
    .ctrl(ctrl_q), .dbl_req_mode(dbl_req_mode), .mux_bus_mode(mux_bus_mode),
    .role(role)
  );

  always_comb begin
    drv_vec          = '0;
    drv_vec[PIN_REQ] = eng_txreq;
    drv_vec[PIN_ACK] = eng_rxreq;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    hpm_pin_cell u_cell (
      .clk(clk), .rst_n(rst_n), .role(role[i]), .gpio_en(ctrl_q[C_GPIO]),
      .dir(dir_q[i]), .dat(dat_q[i]), .host_drv(drv_vec[i]), .pad_in(pin_in[i]),
      .pad_out(pin_out[i]), .pad_oe(pin_oe[i]), .rd_bit(rd_vec[i]),
      .host_rx(rx_vec[i])
    );
    assign pin_is_host[i] = (role[i] != ROLE_GPIO);
  end

  assign eng_ack = rx_vec[PIN_ACK];
  assign eng_cs  = rx_vec[PIN_CS] && !mux_bus_mode;
  assign eng_a10 = rx_vec[PIN_CS] &&  mux_bus_mode;
  assign eng_a9  = rx_vec[PIN_A9];
  assign eng_a8  = rx_vec[PIN_A8];

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {{CTRL_PAD{1'b0}}, ctrl_q};
      A_DIR:   reg_rdata = {{PIN_PAD{1'b0}}, dir_q};
      A_DATA:  reg_rdata = {{PIN_PAD{1'b0}}, rd_vec};
      default: reg_rdata = '0;
    endcase
  end

  AST_ACK_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbl_req_mode && pin_is_host[PIN_ACK]) |-> (ctrl_q[C_ACK] && ctrl_q[C_REQ])); // R4
  AST_DBL_PAIR_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (dbl_req_mode && ctrl_q[C_REQ]) |-> (pin_oe[PIN_ACK] && pin_oe[PIN_REQ])); // R5
  AST_REQ_OFF_GPIO: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[C_REQ] |-> (!pin_is_host[PIN_REQ] && !pin_is_host[PIN_ACK])); // R6
  AST_CS_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eng_cs, eng_a10})); // R7
  AST_ADDR_MUX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !mux_bus_mode |-> (!pin_is_host[PIN_A9] && !pin_is_host[PIN_A8] && !eng_a9 && !eng_a8)); // R8
endmodule

// File: tb/hpm_top_tb.sv
module hpm_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       dbl_req_mode = 1'b0, mux_bus_mode = 1'b0;
  logic       eng_txreq = 1'b0, eng_rxreq = 1'b0;
  logic       eng_ack, eng_cs, eng_a10, eng_a9, eng_a8;
  logic [4:0] pin_in = 5'd0;
  logic [4:0] pin_out, pin_oe, pin_is_host;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  hpm_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dbl_req_mode(dbl_req_mode),
    .mux_bus_mode(mux_bus_mode), .eng_txreq(eng_txreq), .eng_rxreq(eng_rxreq),
    .eng_ack(eng_ack), .eng_cs(eng_cs), .eng_a10(eng_a10), .eng_a9(eng_a9),
    .eng_a8(eng_a8), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_is_host(pin_is_host)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    pin_in = 5'h1F; #1;
    chk("R1 is_host", pin_is_host, 0);
    chk("R1 oe", pin_oe, 0);
    rd(2'd0, v); chk("R1 ctrl", v, 0);
    rd(2'd1, v); chk("R1 dir", v, 0);
    rd(2'd2, v); chk("R1 data", v, 0);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(2'd0, 8'h2A); rd(2'd0, v); chk("R2 ctrl readback", v, 8'h2A);
    wr(2'd1, 8'h15); rd(2'd1, v); chk("R2 dir readback", v, 8'h15);
    wr(2'd3, 8'hFF); rd(2'd3, v); chk("R2 addr3 reads 0", v, 0);
    rd(2'd0, v); chk("R2 ctrl untouched by addr3", v, 8'h2A);
  endtask

  task automatic t_gpio();
    logic [7:0] v;
    dbl_req_mode = 0; mux_bus_mode = 0; pin_in = 5'h1F;
    wr(2'd0, 8'h01); wr(2'd1, 8'h0F); wr(2'd2, 8'h0A);
    chk("R9 oe", pin_oe, 5'h0F);
    chk("R9 out", pin_out[3:0], 4'hA);
    rd(2'd2, v); chk("R10 data read live input", v, 8'h1A);
    wr(2'd0, 8'h00);
    chk("R10 no drive when disabled", pin_oe, 0);
    rd(2'd2, v); chk("R10 disconnected input reads 0", v, 8'h0A);
  endtask

  task automatic t_single();
    dbl_req_mode = 0; mux_bus_mode = 0; eng_txreq = 1; pin_in = 5'h00;
    wr(2'd1, 8'h1F); wr(2'd2, 8'h00); wr(2'd0, 8'h11);
    chk("R3 req pad host", pin_is_host, 5'h01);
    chk("R3 oe", pin_oe, 5'h1F);
    chk("R3 drives txreq", pin_out[0], 1);
    wr(2'd0, 8'h31); pin_in = 5'h02; #1;
    chk("R4 ack pad host", pin_is_host, 5'h03);
    chk("R4 ack pad released", pin_oe, 5'h1D);
    chk("R4 ack follows pad", eng_ack, 1);
    wr(2'd0, 8'h21);
    chk("R4 ack alone is GPIO", pin_is_host, 0);
    chk("R11 ack 0 when not role", eng_ack, 0);
    eng_txreq = 0;
  endtask

  task automatic t_double();
    dbl_req_mode = 1; mux_bus_mode = 0; eng_rxreq = 1; eng_txreq = 0;
    wr(2'd1, 8'h00); wr(2'd0, 8'h11);
    chk("R5 pair host", pin_is_host, 5'h03);
    chk("R5 pair oe", pin_oe, 5'h03);
    chk("R5 rxreq drive", pin_out[1:0], 2'b10);
    wr(2'd0, 8'h31);
    chk("R5 ack enable ignored", pin_is_host, 5'h03);
    chk("R5 ack enable ignored oe", pin_oe, 5'h03);
    wr(2'd0, 8'h21);
    chk("R6 req off both GPIO", pin_is_host, 0);
    chk("R6 req off no drive", pin_oe, 0);
    dbl_req_mode = 0; eng_rxreq = 0;
  endtask

  task automatic t_cs();
    dbl_req_mode = 0; mux_bus_mode = 0; pin_in = 5'h04;
    wr(2'd1, 8'h00); wr(2'd0, 8'h08);
    chk("R7 cs host", pin_is_host, 5'h04);
    chk("R7 cs routed", {eng_cs, eng_a10}, 2'b10);
    mux_bus_mode = 1; #1;
    chk("R7 a10 routed", {eng_cs, eng_a10}, 2'b01);
    chk("R7 only cs pad host in mux", pin_is_host, 5'h04);
    wr(2'd0, 8'h00);
    chk("R7 cs off GPIO", pin_is_host, 0);
    chk("R11 a10 0 when not role", eng_a10, 0);
    mux_bus_mode = 0;
  endtask

  task automatic t_addr();
    logic [7:0] v;
    mux_bus_mode = 0; pin_in = 5'h18;
    wr(2'd1, 8'h00); wr(2'd0, 8'h07);
    chk("R8 ignored non-mux", pin_is_host, 0);
    rd(2'd2, v); chk("R8 pads still GPIO inputs", v, 8'h18);
    mux_bus_mode = 1; #1;
    chk("R8 address pads host", pin_is_host, 5'h18);
    chk("R8 address levels", {eng_a9, eng_a8}, 2'b11);
    rd(2'd2, v); chk("R12 host pads read 0", v, 0);
    mux_bus_mode = 0;
  endtask

  task automatic t_host_vs_gpio_en();
    logic [7:0] v;
    dbl_req_mode = 0; mux_bus_mode = 0; eng_txreq = 0; pin_in = 5'h00;
    wr(2'd1, 8'h01); wr(2'd2, 8'h01); wr(2'd0, 8'h10);
    chk("R11 host out drives with GPIO off", pin_oe, 5'h01);
    chk("R11 level low", pin_out[0], 0);
    eng_txreq = 1; #1;
    chk("R11 level high", pin_out[0], 1);
    rd(2'd2, v); chk("R12 host pad reads 0", v, 0);
    eng_txreq = 0;
  endtask

  initial begin
    bit done = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_gpio();
        t_single();
        t_double();
        t_cs();
        t_addr();
        t_host_vs_gpio_en();
        done = 1;
      end
      begin
        repeat (5000) @(posedge clk);
      end
    join_any
    disable fork;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule